// File: doc/BRIEF.md
# Byte Stack and Context Save Unit

This block owns the stack pointer of a small 8-bit processor and turns each stack-related request into a sequence of single-byte accesses on one RAM port. The stack grows upward. A push stores at the current pointer and then advances it. A pop first steps the pointer back and then reads the byte there. A request can save a register byte, a 16-bit return address, or a full context of return address and flags for an interrupt or supervisor call. It can also restore a register byte, a return address, or a full context.

The core raises a request for one cycle while the unit is not busy. The unit then issues exactly one RAM access per cycle. It pulses a done strobe when the sequence is finished, and at that point the restored register byte, program counter and flags are valid on registered outputs. The RAM is synchronous: read data for an address appears on `mem_rdata` in the cycle after the read is issued. Computing call targets and arbitrating interrupts are handled elsewhere.

Top module: `ctx_stack_unit`

## Requirements
- R1: After synchronous reset the stack pointer is 0x00, `busy` and `done` are low, no RAM access is issued, and `reg_out`, `pc_out` and `flags_out` are zero.
- R2: Operation code 0 (push byte) writes `req_data` at the current pointer in the first cycle after acceptance, increments the pointer, and pulses `done` in the following cycle.
- R3: Operation code 1 (pop byte) reads address pointer-1 and decrements the pointer. When `done` pulses two cycles after the read, `reg_out` holds the byte and flag bit 1 (zero) of `flags_out` is set if the byte is 0x00 and cleared otherwise.
- R4: Operation code 2 (call) writes `req_pc[15:8]` then `req_pc[7:0]` at consecutive pointer values, leaving the pointer two higher.
- R5: Operation code 3 (interrupt entry) writes PC high, PC low, then `req_flags` on three consecutive cycles, leaving the pointer three higher and `flags_out` unchanged.
- R6: Operation code 4 (supervisor entry) saves the same three bytes in the same order as R5, and `flags_out` reads 0x00 when `done` pulses.
- R7: Operation code 5 (return) pops the PC low byte first and then the high byte, and loads both into `pc_out`, leaving the pointer two lower.
- R8: Operation code 6 (return from interrupt) pops the flags, then PC low, then PC high, and loads `flags_out` and `pc_out` from them, leaving the pointer three lower.
- R9: Each cycle carries at most one RAM access, never a read and a write together, and the accesses of a sequence occupy consecutive cycles starting the cycle after acceptance.
- R10: The pointer wraps modulo 256 in both directions: a pop at 0x00 reads 0xFF, and a push at 0xFF leaves the pointer at 0x00.
- R11: Operation code 7 and any request presented while `busy` is high are ignored: no access, no pointer change, no `done`.
- R12: `done` is high for exactly one cycle per accepted request, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 3 | Operation code (0 push, 1 pop, 2 call, 3 interrupt, 4 supervisor, 5 return, 6 return from interrupt, 7 none) |
| req_data | input | 8 | Register byte to push |
| req_pc | input | 16 | Return address to save |
| req_flags | input | 8 | Flag byte to save on context entry |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion strobe |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_addr | output | 8 | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after the read |
| sp_out | output | 8 | Current stack pointer |
| reg_out | output | 8 | Byte restored by the last pop |
| pc_out | output | 16 | Program counter restored by the last return |
| flags_out | output | 8 | Flag register as managed by this unit |

## Verification
The bench aims at byte ordering. A design that saves the PC low byte first, or pops it last, returns a byte-swapped address. A restore that mixes up the flag and PC slots hands back the wrong context. Pointer wrap is exercised by popping from 0x00 and pushing at 0xFF. An unmasked 9-bit increment or decrement would address the wrong RAM byte and corrupt every later access. Requests are also presented mid-sequence and with the unused code. A design that accepts either one would issue extra accesses or move the pointer. The zero flag is checked for popped bytes of both 0x00 and non-zero. The bench also confirms that supervisor entry clears the flags while interrupt entry does not.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_POP  = 3'd1,
    OP_CALL = 3'd2,
    OP_INTR = 3'd3,
    OP_SVC  = 3'd4,
    OP_RET  = 3'd5,
    OP_RETI = 3'd6,
    OP_NONE = 3'd7
  } ctx_op_e;

  // number of RAM byte accesses a request needs
  function automatic logic [1:0] op_len(ctx_op_e op);
    case (op)
      OP_PUSH, OP_POP:          op_len = 2'd1;
      OP_CALL, OP_RET:          op_len = 2'd2;
      OP_INTR, OP_SVC, OP_RETI: op_len = 2'd3;
      default:                  op_len = 2'd0;
    endcase
  endfunction

  // restoring operations read, saving operations write
  function automatic logic op_reads(ctx_op_e op);
    op_reads = (op == OP_POP) || (op == OP_RET) || (op == OP_RETI);
  endfunction

endpackage

// File: rtl/ctx_sp_reg.sv
module ctx_sp_reg #(
  parameter int AW       = 8,
  parameter int SP_RESET = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [AW-1:0] sp
);

  localparam logic [AW-1:0] ONE = AW'(1);

  // natural AW-bit arithmetic gives the modulo wrap
  always_ff @(posedge clk) begin
    if (rst)      sp <= AW'(SP_RESET);
    else if (inc) sp <= sp + ONE;
    else if (dec) sp <= sp - ONE;
  end

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    inc |=> sp == $past(sp) + ONE);  // R2
  AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
    dec |=> sp == $past(sp) - ONE);  // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!inc && !dec) |=> $stable(sp));  // R11

endmodule

// File: rtl/ctx_sequencer.sv
module ctx_sequencer
  import ctx_stack_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  ctx_op_e    op,
  output logic       act,
  output logic       rd,
  output logic [1:0] idx,
  output logic       last,
  output logic       cap_v,
  output logic [1:0] cap_idx,
  output ctx_op_e    op_q,
  output logic       done
);

  logic [1:0] len_q;

  assign last = (idx == len_q - 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      act     <= 1'b0;
      rd      <= 1'b0;
      idx     <= 2'd0;
      len_q   <= 2'd0;
      cap_v   <= 1'b0;
      cap_idx <= 2'd0;
      op_q    <= OP_NONE;
      done    <= 1'b0;
    end else begin
      // write sequences end on their last access, read sequences when the last byte lands
      done    <= (act && !rd && last) || (cap_v && cap_idx == len_q - 2'd1);
      cap_v   <= act && rd;
      cap_idx <= idx;
      if (start) begin
        act   <= 1'b1;
        idx   <= 2'd0;
        op_q  <= op;
        rd    <= op_reads(op);
        len_q <= op_len(op);
      end else if (act) begin
        if (last) act <= 1'b0;
        else      idx <= idx + 2'd1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R12
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (act || cap_v) |-> !start);  // R11

endmodule

// File: rtl/ctx_restore.sv
module ctx_restore
  import ctx_stack_pkg::*;
#(
  parameter int DW       = 8,
  parameter int ZERO_BIT = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  ctx_op_e         op_q,
  input  logic            cap_v,
  input  logic [1:0]      cap_idx,
  input  logic [DW-1:0]   rdata,
  input  logic            flag_clear,
  input  logic            done,
  output logic [DW-1:0]   reg_out,
  output logic [2*DW-1:0] pc_out,
  output logic [DW-1:0]   flags_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_out   <= '0;
      pc_out    <= '0;
      flags_out <= '0;
    end else if (flag_clear) begin
      flags_out <= '0;
    end else if (cap_v) begin
      case (op_q)
        OP_POP: begin
          reg_out             <= rdata;
          flags_out[ZERO_BIT] <= (rdata == '0);
        end
        OP_RET: begin
          if (cap_idx == 2'd0) pc_out[DW-1:0]    <= rdata;
          else                 pc_out[2*DW-1:DW] <= rdata;
        end
        OP_RETI: begin
          case (cap_idx)
            2'd0:    flags_out         <= rdata;
            2'd1:    pc_out[DW-1:0]    <= rdata;
            default: pc_out[2*DW-1:DW] <= rdata;
          endcase
        end
        default: ;
      endcase
    end
  end

  AST_SVC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_SVC) |-> flags_out == '0);  // R6
  AST_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_POP) |-> flags_out[ZERO_BIT] == (reg_out == '0));  // R3

endmodule

// File: rtl/ctx_stack_unit.sv
module ctx_stack_unit
  import ctx_stack_pkg::*;
#(
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int SP_RESET = 0,
  parameter int ZERO_BIT = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [2:0]      req_op,
  input  logic [DW-1:0]   req_data,
  input  logic [2*DW-1:0] req_pc,
  input  logic [DW-1:0]   req_flags,
  output logic            busy,
  output logic            done,
  output logic            mem_we,
  output logic            mem_re,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   sp_out,
  output logic [DW-1:0]   reg_out,
  output logic [2*DW-1:0] pc_out,
  output logic [DW-1:0]   flags_out
);

  localparam int PCW = 2 * DW;

  ctx_op_e     op_in, op_q;
  logic        start, act, rd, last, cap_v;
  logic [1:0]  idx, cap_idx;
  logic [DW-1:0]  data_q, flags_q;
  logic [PCW-1:0] pc_q;

  assign op_in = ctx_op_e'(req_op);
  assign busy  = act | cap_v;
  assign start = req_valid && !busy && (op_in != OP_NONE);

  ctx_sequencer i_seq (
    .clk(clk), .rst(rst), .start(start), .op(op_in),
    .act(act), .rd(rd), .idx(idx), .last(last),
    .cap_v(cap_v), .cap_idx(cap_idx), .op_q(op_q), .done(done)
  );

  ctx_sp_reg #(.AW(AW), .SP_RESET(SP_RESET)) i_sp (
    .clk(clk), .rst(rst), .inc(mem_we), .dec(mem_re), .sp(sp_out)
  );

  ctx_restore #(.DW(DW), .ZERO_BIT(ZERO_BIT)) i_rest (
    .clk(clk), .rst(rst), .op_q(op_q), .cap_v(cap_v), .cap_idx(cap_idx),
    .rdata(mem_rdata), .flag_clear(act && last && op_q == OP_SVC), .done(done),
    .reg_out(reg_out), .pc_out(pc_out), .flags_out(flags_out)
  );

  // operands held for the whole sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      pc_q    <= '0;
      flags_q <= '0;
    end else if (start) begin
      data_q  <= req_data;
      pc_q    <= req_pc;
      flags_q <= req_flags;
    end
  end

  assign mem_we   = act && !rd;
  assign mem_re   = act && rd;
  assign mem_addr = rd ? sp_out - AW'(1) : sp_out;

  // saved byte order: PC high, PC low, flags
  always_comb begin
    case (op_q)
      OP_PUSH: mem_wdata = data_q;
      OP_CALL, OP_INTR, OP_SVC:
        case (idx)
          2'd0:    mem_wdata = pc_q[PCW-1:DW];
          2'd1:    mem_wdata = pc_q[DW-1:0];
          default: mem_wdata = flags_q;
        endcase
      default: mem_wdata = '0;
    endcase
  end

  AST_SINGLE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));  // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_we && !mem_re));  // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);  // R12

endmodule

// File: tb/test_ctx_stack_unit.sv
`timescale 1ns/1ps
module test_ctx_stack_unit;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd7;
  logic [7:0] req_data = '0, req_flags = '0;
  logic [15:0] req_pc = '0;
  logic busy, done, mem_we, mem_re;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, sp_out, reg_out, flags_out;
  logic [15:0] pc_out;

  int errors = 0;
  int checks = 0;
  bit checking = 1'b0;

  always #10 clk = ~clk;

  ctx_stack_unit i_ctx_stack_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_data(req_data), .req_pc(req_pc), .req_flags(req_flags),
    .busy(busy), .done(done), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .sp_out(sp_out), .reg_out(reg_out), .pc_out(pc_out), .flags_out(flags_out)
  );

  // synchronous RAM environment
  logic [7:0] ram [256];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  // reference model
  typedef struct {
    logic we; logic re; logic [7:0] addr; logic [7:0] wd;
    logic busy; logic done; logic chk;
    logic [7:0] sp; logic [7:0] rg; logic [7:0] fl; logic [15:0] pc;
    string tag;
  } exp_t;
  exp_t q[$];
  logic [7:0] m_mem [256];
  logic [7:0] m_sp = 8'h00, m_rg = 8'h00, m_fl = 8'h00;
  logic [15:0] m_pc = 16'h0000;

  function automatic exp_t idle_e(string tag);
    exp_t e;
    e.we = 0; e.re = 0; e.addr = 0; e.wd = 0; e.busy = 0; e.done = 0; e.chk = 0;
    e.sp = m_sp; e.rg = m_rg; e.fl = m_fl; e.pc = m_pc; e.tag = tag;
    return e;
  endfunction

  function automatic void build(input logic [2:0] op, input logic [7:0] d,
                                input logic [15:0] pc, input logic [7:0] fl, input string tag);
    exp_t e;
    logic [7:0] wb [$];
    logic [7:0] val [3];
    int nrd;
    q.push_back(idle_e(tag));
    if (op == 3'd7) begin
      e = idle_e(tag); e.chk = 1; q.push_back(e); q.push_back(e);
      return;
    end
    case (op)
      3'd0: wb = '{d};
      3'd2: wb = '{pc[15:8], pc[7:0]};
      3'd3, 3'd4: wb = '{pc[15:8], pc[7:0], fl};
      default: wb = '{};
    endcase
    nrd = (op == 3'd1) ? 1 : (op == 3'd5) ? 2 : (op == 3'd6) ? 3 : 0;
    foreach (wb[k]) begin
      e = idle_e(tag); e.we = 1; e.addr = m_sp; e.wd = wb[k]; e.busy = 1;
      m_mem[m_sp] = wb[k]; m_sp = m_sp + 8'd1;
      q.push_back(e);
    end
    for (int k = 0; k < nrd; k++) begin
      m_sp = m_sp - 8'd1;
      e = idle_e(tag); e.re = 1; e.addr = m_sp; e.busy = 1;
      val[k] = m_mem[m_sp];
      q.push_back(e);
    end
    if (nrd > 0) begin e = idle_e(tag); e.busy = 1; q.push_back(e); end
    case (op)
      3'd1: begin m_rg = val[0]; m_fl[1] = (val[0] == 8'h00); end
      3'd4: m_fl = 8'h00;
      3'd5: m_pc = {val[1], val[0]};
      3'd6: begin m_fl = val[0]; m_pc = {val[2], val[1]}; end
      default: ;
    endcase
    e = idle_e(tag); e.done = 1; e.chk = 1;
    q.push_back(e);
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      exp_t e;
      bit bad;
      e = (q.size() > 0) ? q.pop_front() : idle_e("R11 idle");
      bad = (mem_we !== e.we) || (mem_re !== e.re) || (busy !== e.busy) || (done !== e.done);
      if ((e.we || e.re) && mem_addr !== e.addr) bad = 1;
      if (e.we && mem_wdata !== e.wd) bad = 1;
      if (e.chk && (sp_out !== e.sp || reg_out !== e.rg || flags_out !== e.fl || pc_out !== e.pc)) bad = 1;
      checks++;
      if (bad) begin
        errors++;
        $display("FAIL %s (R9 R12) got we=%b re=%b a=%h wd=%h busy=%b done=%b sp=%h rg=%h fl=%h pc=%h exp we=%b re=%b a=%h wd=%h busy=%b done=%b sp=%h rg=%h fl=%h pc=%h",
          e.tag, mem_we, mem_re, mem_addr, mem_wdata, busy, done, sp_out, reg_out, flags_out, pc_out,
          e.we, e.re, e.addr, e.wd, e.busy, e.done, e.sp, e.rg, e.fl, e.pc);
      end
    end
  end

  task automatic run_op(input logic [2:0] op, input logic [7:0] d, input logic [15:0] pc,
                        input logic [7:0] fl, input string tag, input int poke);
    @(posedge clk); #2;
    req_valid = 1; req_op = op; req_data = d; req_pc = pc; req_flags = fl;
    build(op, d, pc, fl, tag);
    @(posedge clk); #2;
    if (poke > 0) begin
      req_op = 3'd1;  // R11: a pop presented mid-sequence must be ignored
      repeat (poke) begin @(posedge clk); #2; end
    end
    req_valid = 0; req_op = 3'd7;
    while (q.size() > 0) @(posedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R12 got no completion exp completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      ram[i] = 8'(i) ^ 8'h5A;
      m_mem[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(posedge clk);
    #2 rst = 0;
    @(negedge clk);
    checks++;
    if (sp_out !== 8'h00 || busy !== 0 || done !== 0 || mem_we !== 0 || mem_re !== 0 ||
        reg_out !== 0 || pc_out !== 0 || flags_out !== 0) begin
      errors++;
      $display("FAIL R1 reset got sp=%h busy=%b done=%b rg=%h pc=%h fl=%h exp all zero",
               sp_out, busy, done, reg_out, pc_out, flags_out);
    end
    checking = 1;
    run_op(3'd1, 8'h00, 16'h0, 8'h0, "R3 R10 pop wrap", 0);
    run_op(3'd0, 8'hA5, 16'h0, 8'h0, "R2 R10 push wrap", 0);
    run_op(3'd0, 8'h00, 16'h0, 8'h0, "R2 push zero", 0);
    run_op(3'd1, 8'h00, 16'h0, 8'h0, "R3 pop zero set", 0);
    run_op(3'd1, 8'h00, 16'h0, 8'h0, "R3 pop zero clear", 0);
    run_op(3'd0, 8'h7E, 16'h0, 8'h0, "R2 push", 0);
    run_op(3'd7, 8'h99, 16'hFFFF, 8'hFF, "R11 unused code", 0);
    run_op(3'd2, 8'h00, 16'h1234, 8'h0, "R4 call", 0);
    run_op(3'd5, 8'h00, 16'h0, 8'h0, "R7 return", 0);
    run_op(3'd3, 8'h00, 16'hABCD, 8'h05, "R5 R11 interrupt entry", 2);
    run_op(3'd4, 8'h00, 16'h0F0E, 8'hC7, "R6 supervisor entry", 0);
    run_op(3'd6, 8'h00, 16'h0, 8'h0, "R8 reti inner", 0);
    run_op(3'd6, 8'h00, 16'h0, 8'h0, "R8 reti outer", 0);
    run_op(3'd1, 8'h00, 16'h0, 8'h0, "R3 pop after context", 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    checking = 0;
    summary();
    $finish;
  end

endmodule